// File: doc/BRIEF.md
# Key-Locked System Control Register Bank

This block is a small register bank on a simple 32-bit register bus. It holds a fixed board identifier word, an LED register, an unlock-key register, two set/clear flag registers and a reset-control register. Each bus cycle carries an address, a write strobe, a read strobe and write data. Read data comes back registered: it is valid in the cycle after the read strobe and holds until the next read.

The reset-control register is protected by a 16-bit key. A write to it is accepted only while the key register holds the unlock value. An accepted write can raise a one-cycle reset request, depending on which trigger bit the build selects. The two flag registers each take their set and clear operations at different addresses. One of them is non-volatile. The ordinary reset leaves it alone, and only the power-on reset clears it.

A build parameter picks one of three styles for the reset-control register:
- trigger on data bit 8;
- trigger on data bit 2;
- no register at all: it reads as zero and ignores writes.

Top module: `sysctl_regbank`

## Requirements
- R1: While `rst_n` is low, and after it is released, the LED, key, flag and reset-control registers read as zero. `reset_req`, `bad_access` and `bus_rdata` are also low.
- R2: The non-volatile flags at 0x038 keep their value through `rst_n`. Only `por_n` low clears them.
- R3: A write to 0x020 with data exactly 0x0000A05F stores 0xA05F. Any other write data stores its low 15 bits with bit 15 cleared. A read of 0x020 returns the stored 16-bit value, zero-extended.
- R4: The bank is unlocked only while the stored key equals 0xA05F.
- R5: A write to 0x030 ORs the data into the flags. A write to 0x034 clears the flag bits that are set in the data. A read of 0x030 returns the flags.
- R6: Writes to 0x038 (set) and 0x03C (clear) act the same way on the non-volatile flags. A read of 0x038 returns them.
- R7: A write to 0x040 stores the whole data word only while the bank is unlocked. A read of 0x040 returns the stored word. A write made while locked changes nothing.
- R8: When a write to 0x040 is accepted and the style's trigger bit is 1 in the write data, `reset_req` is high for exactly the cycle after that write. The trigger is bit 8 for style 1 and bit 2 for style 2.
- R9: In style 0, a read of 0x040 returns zero, writes to 0x040 are ignored, and `reset_req` never rises.
- R10: A read of 0x000 returns the `ID_WORD` parameter, whose board-type field is bits [27:16]. Writes to 0x000 are ignored.
- R11: A write to 0x008 stores the LED register. A read of 0x008 returns it.
- R12: A read of any other offset, including 0x034 and 0x03C, returns zero and sets `bad_access` for one cycle. A write to any other offset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset for all state except the non-volatile flags |
| por_n | input | 1 | Asynchronous active-low power-on reset for the non-volatile flags |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bad_access | output | 1 | One-cycle pulse after a read of an unmapped offset |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The assertions check four properties on every cycle:
- the key register's bit-15 rule;
- that a write of the key unlocks the bank;
- that set and clear writes have their effect on both flag registers;
- that a locked reset-control write leaves the stored word unchanged and that every `reset_req` pulse follows an unlocked reset-control write.

They also check that `bad_access` comes with zero read data and that the identifier reads back intact. The bench's scenarios are needed for the rest:
- the split between the two reset inputs;
- the different behaviour of the three reset-control styles, with three instances sharing one bus;
- the sequences that lock, unlock and re-lock the bank.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_ID    = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_LED   = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_KEY   = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_FSET  = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_FCLR  = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_NVSET = 12'h038;
  localparam logic [ADDR_W-1:0] OFS_NVCLR = 12'h03C;
  localparam logic [ADDR_W-1:0] OFS_RCTL  = 12'h040;

  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;

  typedef enum logic [1:0] {
    RST_NONE = 2'd0,
    RST_BIT8 = 2'd1,
    RST_BIT2 = 2'd2
  } rst_style_e;
endpackage

// File: rtl/sysctl_lock.sv
module sysctl_lock #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [15:0]       key_q,
  output logic              unlocked
);
  import sysctl_pkg::*;

  logic [15:0] key_d;
  logic        is_key;

  assign is_key = (wdata == DATA_W'(UNLOCK_KEY));

  always_comb begin
    key_d = key_q;
    if (wr_en) begin
      if (is_key) key_d = UNLOCK_KEY;
      else        key_d = {1'b0, wdata[14:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_q <= '0;
    else        key_q <= key_d;
  end

  assign unlocked = (key_q == UNLOCK_KEY);

  // R3
  key_bit15_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata != DATA_W'(UNLOCK_KEY)) |=> !key_q[15]);
  // R4
  key_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata == DATA_W'(UNLOCK_KEY)) |=> unlocked);
endmodule

// File: rtl/sysctl_setclr.sv
module sysctl_setclr #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] d;

  always_comb begin
    d = q;
    if (set_en)      d = q | wdata;
    else if (clr_en) d = q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  // R5 R6
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((q & $past(wdata)) == $past(wdata)));
  // R5 R6
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> ((q & $past(wdata)) == '0));
endmodule

// File: rtl/sysctl_rstctl.sv
module sysctl_rstctl #(
  parameter int unsigned            DATA_W = 32,
  parameter sysctl_pkg::rst_style_e STYLE  = sysctl_pkg::RST_BIT8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              unlocked,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] level_q,
  output logic              reset_req
);
  import sysctl_pkg::*;

  logic              accept;
  logic              trig;
  logic [DATA_W-1:0] level_d;
  logic              req_d;

  generate
    if (STYLE == RST_NONE) begin : g_none
      assign accept = 1'b0;
      assign trig   = 1'b0;
    end else begin : g_live
      localparam int unsigned TRIG_BIT = (STYLE == RST_BIT2) ? 2 : 8;
      assign accept = wr_en & unlocked;
      assign trig   = wdata[TRIG_BIT];
    end
  endgenerate

  always_comb begin
    level_d = level_q;
    req_d   = 1'b0;
    if (accept) begin
      level_d = wdata;
      req_d   = trig;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q   <= '0;
      reset_req <= 1'b0;
    end else begin
      level_q   <= level_d;
      reset_req <= req_d;
    end
  end

  // R7
  locked_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlocked) |=> $stable(level_q));
  // R8
  req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(wr_en && unlocked));
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank #(
  parameter int unsigned            DATA_W    = 32,
  parameter logic [DATA_W-1:0]      ID_WORD   = 32'h0179_0A0B,
  parameter sysctl_pkg::rst_style_e RST_STYLE = sysctl_pkg::RST_BIT8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          por_n,
  input  logic [sysctl_pkg::ADDR_W-1:0] bus_addr,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  output logic                          bad_access,
  output logic                          reset_req
);
  import sysctl_pkg::*;

  logic              wr_led, wr_key, wr_fset, wr_fclr, wr_nvset, wr_nvclr, wr_rctl;
  logic [DATA_W-1:0] led_q, led_d;
  logic [15:0]       key_q;
  logic              unlocked;
  logic [DATA_W-1:0] flags_q, nvflags_q, level_q;
  logic [DATA_W-1:0] rd_val, rdata_d;
  logic              rd_miss, bad_d;

  assign wr_led   = bus_wr && bus_addr == OFS_LED;
  assign wr_key   = bus_wr && bus_addr == OFS_KEY;
  assign wr_fset  = bus_wr && bus_addr == OFS_FSET;
  assign wr_fclr  = bus_wr && bus_addr == OFS_FCLR;
  assign wr_nvset = bus_wr && bus_addr == OFS_NVSET;
  assign wr_nvclr = bus_wr && bus_addr == OFS_NVCLR;
  assign wr_rctl  = bus_wr && bus_addr == OFS_RCTL;

  sysctl_lock #(.DATA_W(DATA_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_key), .wdata(bus_wdata),
    .key_q(key_q), .unlocked(unlocked)
  );

  sysctl_setclr #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_en(wr_fset), .clr_en(wr_fclr),
    .wdata(bus_wdata), .q(flags_q)
  );

  sysctl_setclr #(.DATA_W(DATA_W)) u_nvflags (
    .clk(clk), .rst_n(por_n), .set_en(wr_nvset), .clr_en(wr_nvclr),
    .wdata(bus_wdata), .q(nvflags_q)
  );

  sysctl_rstctl #(.DATA_W(DATA_W), .STYLE(RST_STYLE)) u_rstctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_rctl), .unlocked(unlocked),
    .wdata(bus_wdata), .level_q(level_q), .reset_req(reset_req)
  );

  always_comb begin
    led_d = led_q;
    if (wr_led) led_d = bus_wdata;
  end

  always_comb begin
    rd_val  = '0;
    rd_miss = 1'b0;
    case (bus_addr)
      OFS_ID:    rd_val = ID_WORD;
      OFS_LED:   rd_val = led_q;
      OFS_KEY:   rd_val = DATA_W'(key_q);
      OFS_FSET:  rd_val = flags_q;
      OFS_NVSET: rd_val = nvflags_q;
      OFS_RCTL:  rd_val = level_q;
      default:   rd_miss = 1'b1;
    endcase
  end

  always_comb begin
    rdata_d = bus_rdata;
    bad_d   = 1'b0;
    if (bus_rd) begin
      rdata_d = rd_val;
      bad_d   = rd_miss;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q      <= '0;
      bus_rdata  <= '0;
      bad_access <= 1'b0;
    end else begin
      led_q      <= led_d;
      bus_rdata  <= rdata_d;
      bad_access <= bad_d;
    end
  end

  // R12
  bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> (bus_rdata == '0 && $past(bus_rd)));
  // R10
  id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_ID) |=> (bus_rdata == ID_WORD));
endmodule

// File: tb/test_sysctl_regbank.sv
module test_sysctl_regbank;
  localparam logic [31:0] IDW = 32'h0179_0A0B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata [3];
  logic        bad   [3];
  logic        req   [3];

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sysctl_regbank #(.ID_WORD(IDW), .RST_STYLE(sysctl_pkg::RST_BIT8)) i_sysctl_regbank (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdata[1]), .bad_access(bad[1]),
    .reset_req(req[1]));
  sysctl_regbank #(.ID_WORD(IDW), .RST_STYLE(sysctl_pkg::RST_BIT2)) i_sysctl_regbank_b (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdata[2]), .bad_access(bad[2]),
    .reset_req(req[2]));
  sysctl_regbank #(.ID_WORD(IDW), .RST_STYLE(sysctl_pkg::RST_NONE)) i_sysctl_regbank_c (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdata[0]), .bad_access(bad[0]),
    .reset_req(req[0]));

  // Behavioural reference model; index = reset style (0 none, 1 bit 8, 2 bit 2)
  logic [31:0] m_led, m_flags, m_nv;
  logic [15:0] m_key;
  logic [31:0] m_lvl [3];
  logic [31:0] m_rd  [3];
  logic        m_req [3];
  logic        m_bad;
  logic [11:0] last_rd;

  function automatic string tag_of(input logic [11:0] a);
    case (a)
      12'h000: return "R10";
      12'h008: return "R11";
      12'h020: return "R3";
      12'h030: return "R5";
      12'h038: return "R6";
      12'h040: return "R7";
      default: return "R12";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n or negedge por_n) begin
    if (!por_n) m_nv = '0;
    if (!rst_n) begin
      m_led = '0; m_key = '0; m_flags = '0; m_bad = 0; last_rd = '0;
      for (int v = 0; v < 3; v++) begin m_lvl[v] = '0; m_rd[v] = '0; m_req[v] = 0; end
    end else if (por_n || 1) begin
      m_bad = 0;
      for (int v = 0; v < 3; v++) m_req[v] = 0;
      if (bus_rd) begin
        last_rd = bus_addr;
        m_bad = !(bus_addr inside {12'h000, 12'h008, 12'h020, 12'h030, 12'h038, 12'h040});
        for (int v = 0; v < 3; v++) begin
          case (bus_addr)
            12'h000: m_rd[v] = IDW;
            12'h008: m_rd[v] = m_led;
            12'h020: m_rd[v] = {16'h0, m_key};
            12'h030: m_rd[v] = m_flags;
            12'h038: m_rd[v] = m_nv;
            12'h040: m_rd[v] = (v == 0) ? 32'h0 : m_lvl[v];
            default: m_rd[v] = 32'h0;
          endcase
        end
      end
      if (bus_wr) begin
        case (bus_addr)
          12'h008: m_led = bus_wdata;
          12'h030: m_flags = m_flags | bus_wdata;
          12'h034: m_flags = m_flags & ~bus_wdata;
          12'h038: if (por_n) m_nv = m_nv | bus_wdata;
          12'h03C: if (por_n) m_nv = m_nv & ~bus_wdata;
          12'h040: if (m_key == 16'hA05F) begin
            m_lvl[1] = bus_wdata; m_req[1] = bus_wdata[8];
            m_lvl[2] = bus_wdata; m_req[2] = bus_wdata[2];
          end
          12'h020: m_key = (bus_wdata == 32'h0000A05F) ? 16'hA05F : {1'b0, bus_wdata[14:0]};
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h at %0t", tag, got, exp, $time);
    end
  endtask

  // Per-cycle comparison, sampled away from the clock edge
  always @(posedge clk) begin
    #5;
    if (!done) begin
      for (int v = 0; v < 3; v++) begin
        chk(tag_of(last_rd), rdata[v], m_rd[v]);
        chk((v == 0) ? "R9" : "R8", {31'h0, req[v]}, {31'h0, m_req[v]});
      end
      chk("R12", {31'h0, bad[1]}, {31'h0, m_bad});
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    // R1 reset state
    @(negedge clk);
    chk("R1", {31'h0, req[1]}, 32'h0);
    chk("R1", rdata[1], 32'h0);
    rd(12'h008); rd(12'h020); rd(12'h030); rd(12'h040);
    // R10 identifier, read-only
    rd(12'h000); wr(12'h000, 32'hFFFF_FFFF); rd(12'h000);
    chk("R10", rdata[1], IDW);
    // R11 LED
    wr(12'h008, 32'h0000_00A5); rd(12'h008);
    // R5 flags set/clear
    wr(12'h030, 32'h0000_F0F0); wr(12'h030, 32'h0000_000F);
    wr(12'h034, 32'h0000_00F0); rd(12'h030);
    chk("R5", rdata[1], 32'h0000_F00F);
    // R12 write-only offsets read as unmapped
    rd(12'h034); rd(12'h03C);
    // R6 non-volatile flags
    wr(12'h038, 32'h8000_0011); wr(12'h03C, 32'h0000_0001); rd(12'h038);
    chk("R6", rdata[1], 32'h8000_0010);
    // R7 locked write ignored
    wr(12'h040, 32'h0000_0104); rd(12'h040);
    chk("R7", rdata[1], 32'h0);
    // R3 R4 key rules
    wr(12'h020, 32'h0000_FFFF); rd(12'h020);
    chk("R3", rdata[1], 32'h0000_7FFF);
    wr(12'h020, 32'h0001_A05F); rd(12'h020);
    wr(12'h040, 32'h0000_0100); rd(12'h040);
    chk("R4", rdata[1], 32'h0);
    wr(12'h020, 32'h0000_A05F); rd(12'h020);
    // R8 R9 trigger bits per style
    wr(12'h040, 32'h0000_0100); rd(12'h040);
    chk("R7", rdata[1], 32'h0000_0100);
    chk("R9", rdata[0], 32'h0);
    wr(12'h040, 32'h0000_0004); wr(12'h040, 32'h0000_0104); rd(12'h040);
    // re-lock
    wr(12'h020, 32'h0000_1234); wr(12'h040, 32'h0000_0104); rd(12'h040);
    chk("R4", rdata[2], 32'h0000_0104);
    // R12 unmapped
    wr(12'h0FC, 32'hDEAD_BEEF); rd(12'h0FC); rd(12'h008);
    // R2 rst_n keeps non-volatile flags
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    rd(12'h038);
    chk("R2", rdata[1], 32'h8000_0010);
    rd(12'h008);
    chk("R1", rdata[1], 32'h0);
    @(negedge clk); por_n = 0; @(negedge clk); por_n = 1;
    rd(12'h038);
    chk("R2", rdata[1], 32'h0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule